// File: doc/BRIEF.md
# Pipelined Unsigned Restoring Divider

This block divides an N-bit unsigned dividend by an M-bit unsigned divisor (N ≥ M). It returns an N-bit quotient and an M-bit remainder. The work is spread over N pipeline stages, with one register rank after each stage. Each stage handles one dividend bit. It appends that bit to the running partial remainder and trial-subtracts the divisor by adding its inverse with a carry-in of one. The carry-out then does two jobs: it becomes the quotient bit, and it chooses between the difference and the unchanged minuend. The first M stages are M bits wide and the later stages are M+1 bits wide.

The divisor, the dividend and the quotient bits produced so far all travel down the pipe next to their partial remainder. A fresh operand pair can therefore enter on every clock. The datapath registers advance on every edge. The qualifying input only feeds a separate N-deep flag chain, and that chain tells the consumer which output cycles hold a requested result.

Top module: `pipeDivider`

## Requirements
- R1: For a nonzero divisor the result is quotient = floor(dividend / divisor) and remainder = dividend mod divisor. After every valid result, quotient × divisor + remainder equals the dividend and the remainder is below the divisor.
- R2: For a zero divisor the quotient is all ones (2^N − 1) and the remainder equals the low M bits of the dividend.
- R3: Operands sampled at rising edge k produce their quotient and remainder at the outputs just after rising edge k+N−1, which is the N-th edge counting the sampling edge. The outputs hold there until the next edge.
- R4: resultValid is high after edge k+N−1 exactly when enable was high at edge k.
- R5: A new operand pair may be applied on every clock. Back-to-back pairs give independent, correct results.
- R6: enable has no effect on the datapath. A result requested with enable high is correct whatever enable was for the pairs before and after it.
- R7: resetN low clears resultValid at once, without waiting for a clock edge, and holds it low.
- R8: A dividend smaller than the divisor gives quotient 0 and remainder equal to the dividend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| resetN | input | 1 | Asynchronous active-low reset of the valid chain |
| enable | input | 1 | Marks the current operand pair as a requested division |
| dividend | input | N | Unsigned dividend |
| divisor | input | M | Unsigned divisor |
| quotient | output | N | Unsigned quotient |
| remainder | output | M | Unsigned remainder |
| resultValid | output | 1 | High when quotient and remainder belong to a requested pair |

## Verification
The properties assume that every pair entered with enable high carries known operand values. They also assume that enable is held low while resetN is low, so the data reaching the last stage in a valid cycle belongs to that pair. For this reason the arithmetic checks are gated on resultValid, and they read the divisor and dividend that arrive at the final stage together with the result. The stimulus changes inputs only on the falling clock edge and keeps enable low throughout each reset. It also uses zero divisors and dividends below the divisor on purpose, because the arithmetic properties have to cover those cases too.

// File: rtl/divPkg.sv
package divPkg;
  // Strobes the control side hands to the top
  typedef struct packed {
    logic outValid;
  } divCtl_t;
endpackage

// File: rtl/divStage.sv
module divStage #(
  parameter int W = 5,
  parameter int M = 4
) (
  input  logic [W-1:0] minuend,
  input  logic [M-1:0] divisor,
  output logic         geFlag,
  output logic [W-1:0] rest
);
  logic [W-1:0] divExt;
  logic [W:0]   total;

  always_comb begin
    divExt = W'(divisor);
    // subtraction as minuend + not(divisor) + 1; the carry-out means minuend >= divisor
    total  = {1'b0, minuend} + {1'b0, ~divExt} + (W+1)'(1);
    geFlag = total[W];
    rest   = geFlag ? total[W-1:0] : minuend;
  end
endmodule

// File: rtl/divDatapath.sv
module divDatapath #(
  parameter int N = 8,
  parameter int M = 4
) (
  input  logic         clk,
  input  logic [N-1:0] dividend,
  input  logic [M-1:0] divisor,
  output logic [N-1:0] quotient,
  output logic [M-1:0] remainder,
  output logic [N-1:0] tailDividend,
  output logic [M-1:0] tailDivisor
);
  localparam int LAST = N - 1;

  logic [M-1:0] remReg [N];
  logic [M-1:0] divReg [N];
  logic [N-1:0] dvdReg [N];
  logic [N-1:0] qReg   [N];

  for (genvar i = 0; i < N; i++) begin : gStage
    localparam int W = (i < M) ? M : M + 1;
    logic [M-1:0] prevRem;
    logic [M-1:0] prevDiv;
    logic [N-1:0] prevDvd;
    logic [N-1:0] prevQ;
    logic [W-1:0] minuend;
    logic [W-1:0] rest;
    logic         geFlag;

    if (i == 0) begin : gHead
      assign prevRem = '0;
      assign prevDiv = divisor;
      assign prevDvd = dividend;
      assign prevQ   = '0;
    end else begin : gBody
      assign prevRem = remReg[i-1];
      assign prevDiv = divReg[i-1];
      assign prevDvd = dvdReg[i-1];
      assign prevQ   = qReg[i-1];
    end

    if (W == M) begin : gNarrow
      assign minuend = {prevRem[M-2:0], prevDvd[N-1-i]};
    end else begin : gWide
      assign minuend = {prevRem, prevDvd[N-1-i]};
    end

    divStage #(.W(W), .M(M)) uStage (
      .minuend(minuend),
      .divisor(prevDiv),
      .geFlag (geFlag),
      .rest   (rest)
    );

    always_ff @(posedge clk) begin
      remReg[i] <= rest[M-1:0];
      divReg[i] <= prevDiv;
      dvdReg[i] <= prevDvd;
      qReg[i]   <= {prevQ[N-2:0], geFlag};
    end
  end

  assign quotient     = qReg[LAST];
  assign remainder    = remReg[LAST];
  assign tailDividend = dvdReg[LAST];
  assign tailDivisor  = divReg[LAST];
endmodule

// File: rtl/divValidCtl.sv
module divValidCtl #(
  parameter int N = 8
) (
  input  logic            clk,
  input  logic            resetN,
  input  logic            enable,
  output divPkg::divCtl_t ctl
);
  logic [N-1:0] flagChain;

  always_ff @(posedge clk or negedge resetN) begin
    if (!resetN) flagChain <= '0;
    else         flagChain <= {flagChain[N-2:0], enable};
  end

  always_comb ctl.outValid = flagChain[N-1];
endmodule

// File: rtl/pipeDivider.sv
module pipeDivider #(
  parameter int N = 8,
  parameter int M = 4
) (
  input  logic         clk,
  input  logic         resetN,
  input  logic         enable,
  input  logic [N-1:0] dividend,
  input  logic [M-1:0] divisor,
  output logic [N-1:0] quotient,
  output logic [M-1:0] remainder,
  output logic         resultValid
);
  divPkg::divCtl_t ctl;
  logic [N-1:0]    tailDividend;
  logic [M-1:0]    tailDivisor;

  divValidCtl #(.N(N)) uCtl (
    .clk   (clk),
    .resetN(resetN),
    .enable(enable),
    .ctl   (ctl)
  );

  divDatapath #(.N(N), .M(M)) uPath (
    .clk         (clk),
    .dividend    (dividend),
    .divisor     (divisor),
    .quotient    (quotient),
    .remainder   (remainder),
    .tailDividend(tailDividend),
    .tailDivisor (tailDivisor)
  );

  assign resultValid = ctl.outValid;
endmodule

// File: rtl/divChecker.sv
module divChecker #(
  parameter int N = 8,
  parameter int M = 4
) (
  input logic         clk,
  input logic         resetN,
  input logic         resultValid,
  input logic [N-1:0] quotient,
  input logic [M-1:0] remainder,
  input logic [N-1:0] tailDividend,
  input logic [M-1:0] tailDivisor
);
  logic [N+M:0] rebuilt;
  always_comb rebuilt = (N+M+1)'(quotient) * (N+M+1)'(tailDivisor) + (N+M+1)'(remainder);

  // R1
  identity_chk: assert property (@(posedge clk) disable iff (!resetN)
    (resultValid && tailDivisor != '0) |-> (rebuilt == (N+M+1)'(tailDividend)));

  // R1
  rem_below_div_chk: assert property (@(posedge clk) disable iff (!resetN)
    (resultValid && tailDivisor != '0) |-> (remainder < tailDivisor));

  // R2
  zero_div_chk: assert property (@(posedge clk) disable iff (!resetN)
    (resultValid && tailDivisor == '0) |-> (quotient == '1 && remainder == tailDividend[M-1:0]));

  // R8
  small_dvd_chk: assert property (@(posedge clk) disable iff (!resetN)
    (resultValid && (N)'(tailDivisor) > tailDividend) |-> (quotient == '0 && (N)'(remainder) == tailDividend));

  // R7
  always @(posedge clk) begin
    if (!resetN) valid_cleared_chk: assert (!resultValid);
  end
endmodule

bind pipeDivider divChecker #(.N(N), .M(M)) uChk (
  .clk         (clk),
  .resetN      (resetN),
  .resultValid (resultValid),
  .quotient    (quotient),
  .remainder   (remainder),
  .tailDividend(tailDividend),
  .tailDivisor (tailDivisor)
);

// File: tb/tb_pipeDivider.sv
module tb_pipeDivider;
  localparam int N = 8;
  localparam int M = 4;

  logic         clk = 1'b0;
  logic         resetN = 1'b0;
  logic         enable = 1'b0;
  logic [N-1:0] dividend = '0;
  logic [M-1:0] divisor = '0;
  logic [N-1:0] quotient;
  logic [M-1:0] remainder;
  logic         resultValid;

  always #2 clk = ~clk;  // 250 MHz

  pipeDivider #(.N(N), .M(M)) dut (
    .clk(clk), .resetN(resetN), .enable(enable),
    .dividend(dividend), .divisor(divisor),
    .quotient(quotient), .remainder(remainder), .resultValid(resultValid)
  );

  typedef struct { bit en; int a; int b; } rec_t;
  rec_t hist[$];
  int   checks = 0;
  int   fails = 0;
  bit   tracking = 1'b0;

  // history of sampled inputs, newest at the back, at most N deep
  always @(posedge clk) begin
    rec_t r;
    if (tracking) begin
      r.en = enable; r.a = int'(dividend); r.b = int'(divisor);
      hist.push_back(r);
      if (hist.size() > N) void'(hist.pop_front());
    end
  end

  // compare every cycle, away from the rising edge (R3 alignment)
  always @(negedge clk) begin
    bit expV;
    int expQ, expR;
    string tag;
    if (tracking) begin
      expV = (hist.size() == N) ? hist[0].en : 1'b0;
      checks++;
      if (resultValid !== expV) begin
        fails++;
        $display("FAIL R4 resultValid actual=%0b expected=%0b", resultValid, expV);
      end
      if (expV) begin
        if (hist[0].b == 0) begin
          expQ = (1 << N) - 1; expR = hist[0].a % (1 << M); tag = "R2";
        end else begin
          expQ = hist[0].a / hist[0].b; expR = hist[0].a % hist[0].b;
          tag = (hist[0].a < hist[0].b) ? "R8" : "R1";
        end
        checks++;
        if (int'(quotient) != expQ || int'(remainder) != expR) begin
          fails++;
          $display("FAIL %s/R3 a=%0d b=%0d actual q=%0d r=%0d expected q=%0d r=%0d",
                   tag, hist[0].a, hist[0].b, quotient, remainder, expQ, expR);
        end
      end
    end
  end

  task automatic drive(input bit e, input int a, input int b);
    @(negedge clk);
    enable = e; dividend = a[N-1:0]; divisor = b[M-1:0];
  endtask

  task automatic doReset();
    @(negedge clk);
    tracking = 1'b0; enable = 1'b0; resetN = 1'b0;
    #0.5;
    checks++;
    if (resultValid !== 1'b0) begin
      fails++;
      $display("FAIL R7 resultValid during reset actual=%0b expected=0", resultValid);
    end
    hist.delete();
    repeat (2) @(negedge clk);
    resetN = 1'b1; tracking = 1'b1;
  endtask

  task automatic finish();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1;
    checks++;
    if (resultValid !== 1'b0) begin
      fails++;
      $display("FAIL R7 reset state actual=%0b expected=0", resultValid);
    end
    repeat (3) @(negedge clk);
    resetN = 1'b1; tracking = 1'b1;

    // directed: general, zero divisor (R2), small dividend (R8), extremes (R1)
    drive(1, 140, 9);
    drive(1, 200, 0);
    drive(1, 5, 11);
    drive(1, 255, 1);
    drive(1, 255, 15);
    drive(1, 0, 7);
    drive(1, 0, 0);
    drive(1, 128, 15);
    drive(1, 14, 15);
    // R6: a lone request between idle pairs that still carry data
    drive(0, 77, 3);
    drive(1, 99, 7);
    drive(0, 13, 0);
    repeat (N + 2) drive(0, 0, 0);

    // R5/R6: back-to-back pairs, enable toggling at random
    for (int i = 0; i < 2000; i++) begin
      drive($urandom_range(0, 1), $urandom_range(0, (1 << N) - 1), $urandom_range(0, (1 << M) - 1));
    end

    // R7: reset in the middle of a stream of requests
    for (int i = 0; i < 5; i++) drive(1, 100 + i, 3);
    doReset();
    for (int i = 0; i < 300; i++) begin
      drive(1, $urandom_range(0, (1 << N) - 1), $urandom_range(0, (1 << M) - 1));
    end
    repeat (N + 2) drive(0, 0, 0);
    finish();
  end

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish();
  end
endmodule